// File: doc/BRIEF.md
# Processor Exception and Interrupt Entry Controller

This block sits beside a small 32-bit soft processor pipeline. It watches the event sources that can take the processor away from its instruction stream: a level interrupt line, a hardware-exception pulse, a translation-fault pulse and a break request. Each cycle it picks at most one event. For that event it sends the pipeline to the event's vector, writes a return address to a fixed general register, and updates the status, exception-status, fault-address and saved-branch-target registers that it owns.

Every entry happens in one clock edge. In the following cycle the block raises a one-cycle `flush` pulse together with the new PC and the register-file write. The pipeline uses that pulse to squash the instruction in flight and to clear its delay-slot and prefix flags. Return addresses after a translation fault are moved back, so that a faulting delay-slot branch, or the immediate prefix in front of a faulting instruction, runs again. Every entry saves the user and translation mode bits and then clears them, so the handler runs privileged with translation off. The pipeline writes the status register through a plain write port. A separate input sets the load-reserved reservation, and any entry clears it.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The vector is `BASE_VEC` plus a fixed offset: 0x10 for an interrupt, 0x18 for a break, and 0x20 for both a hardware exception and a translation fault.
- R2: When several events are present in one cycle, the translation fault wins, then the hardware exception, then the break, then the interrupt. Only one entry is made per cycle.
- R3: An interrupt is taken only when status bit 1 (interrupt enable) is set, status bits 9 (exception in progress) and 3 (break in progress) are clear, and neither `in_dslot` nor `in_imm` is set. Otherwise nothing changes and `flush` stays low.
- R4: An interrupt entry clears status bit 1 and writes `cur_pc` to register 14.
- R5: A break is taken only when status bit 3 is clear and neither `in_dslot` nor `in_imm` is set. It sets status bit 3 and writes `cur_pc` to register 16.
- R6: A hardware exception sets status bit 9 and writes `cur_pc`+4 to register 17. It loads the exception status with `hwexc_cause` in bits [4:0] and `in_dslot` in bit 12. In a delay slot it also copies `br_target` into the saved branch target.
- R7: A translation fault sets status bit 9 and writes register 17 with a moved-back address. In a delay slot this is `cur_pc`-8 when `in_bimm` is set and `cur_pc`-4 otherwise. With `in_imm` alone it is `cur_pc`-4. In all other cases it is `cur_pc`.
- R8: A translation fault loads the exception status with a code in bits [4:0]. The code is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is set for a store and bit 12 is set in a delay slot. `fault_addr` goes to the fault-address register, and `br_target` goes to the saved branch target when in a delay slot.
- R9: On every entry, status bit 11 (user) is copied to bit 12 and bit 13 (translation) is copied to bit 14. Bits 11 and 13 are then cleared.
- R10: Every entry clears `resv_valid` and gives a `flush` pulse (with `rf_we`) lasting exactly one cycle, in the cycle after the event is sampled.
- R11: With `EXC_EN` = 0, a hardware exception is ignored and changes no state. A lower-priority event in the same cycle is still taken.
- R12: After reset, `flush`, `rf_we`, `new_pc`, `stat_q`, `esr_q`, `ear_q`, `btr_q` and `resv_valid` are all zero.
- R13: `stat_wr_en` loads `stat_wr_data` into the status register when no entry is made. In a cycle with an entry, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Level interrupt request |
| hwexc_req | input | 1 | Hardware exception pulse |
| hwexc_cause | input | 5 | Cause code for a hardware exception |
| mmu_fault | input | 1 | Translation fault pulse |
| mmu_miss | input | 1 | 1 = miss, 0 = protection fault |
| mmu_fetch | input | 1 | Fault was on an instruction fetch |
| mmu_store | input | 1 | Fault was on a store |
| fault_addr | input | 32 | Faulting address |
| brk_req | input | 1 | Break request (level) |
| cur_pc | input | 32 | PC of the current instruction |
| br_target | input | 32 | Target of the pending branch |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| in_imm | input | 1 | Current instruction follows an immediate prefix |
| in_bimm | input | 1 | Delay-slot branch had an immediate prefix |
| stat_wr_en | input | 1 | Status register write strobe |
| stat_wr_data | input | 32 | Status register write value |
| resv_set | input | 1 | Sets the load-reserved reservation |
| flush | output | 1 | One-cycle redirect and squash pulse |
| new_pc | output | 32 | Vector address |
| rf_we | output | 1 | Return-address register write enable |
| rf_idx | output | 5 | Return-address register index |
| rf_data | output | 32 | Return address |
| stat_q | output | 32 | Status register |
| esr_q | output | 32 | Exception status register |
| ear_q | output | 32 | Fault address register |
| btr_q | output | 32 | Saved branch target register |
| resv_valid | output | 1 | Load-reserved reservation valid |

## Verification
The hardest case to produce is an event whose outcome depends on status bits that an earlier entry already changed. A previous exception leaves exception-in-progress set, and that silently blocks later interrupts. Each table row therefore first writes a known status value through the write port. It then applies the event, together with its delay-slot and prefix flags, in the next cycle. This makes every row independent of the ones before it. The priority, the blocked-interrupt and the ignored-exception cases are driven as several simultaneous requests in one cycle. A second instance built without exception support shares the same stimulus.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry controller.
// Assumes a 32-bit datapath and a 5-bit register index.
package exc_entry_pkg;
    localparam int XLEN = 32;
    localparam int RIDX_W = 5;

    // status register bit positions; saved-mode bits sit one above live ones
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_VM  = 13;
    localparam int N_MODE = 2;

    // exception status bit positions
    localparam int ES_STORE = 10;
    localparam int ES_DS    = 12;

    // return register indices
    localparam logic [RIDX_W-1:0] RA_IRQ = 5'd14;
    localparam logic [RIDX_W-1:0] RA_BRK = 5'd16;
    localparam logic [RIDX_W-1:0] RA_EXC = 5'd17;

    // vector offsets
    localparam logic [XLEN-1:0] OFS_IRQ = 32'h10;
    localparam logic [XLEN-1:0] OFS_BRK = 32'h18;
    localparam logic [XLEN-1:0] OFS_EXC = 32'h20;

    // translation fault syndrome base code
    localparam logic [4:0] MMU_CODE_BASE = 5'd16;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_MMU,
        EV_HW,
        EV_BRK,
        EV_IRQ
    } ev_e;
endpackage

// File: rtl/exc_arbiter.sv
// Chooses at most one event per cycle. Order: translation fault,
// hardware exception, break, interrupt. Assumes fault and exception
// inputs are single-cycle pulses; break and interrupt are levels.
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter bit EXC_EN = 1'b1
) (
    input  logic irq_req,
    input  logic hwexc_req,
    input  logic mmu_fault,
    input  logic brk_req,
    input  logic st_ie,
    input  logic st_bip,
    input  logic st_eip,
    input  logic in_dslot,
    input  logic in_imm,
    output ev_e  ev
);
    logic seq_free;
    logic irq_ok;
    logic brk_ok;
    logic hw_ok;

    // qualify each request against status and instruction state
    always_comb begin
        seq_free = !in_dslot && !in_imm;
        irq_ok   = irq_req && st_ie && !st_eip && !st_bip && seq_free;
        brk_ok   = brk_req && !st_bip && seq_free;
        hw_ok    = hwexc_req && EXC_EN;
    end

    // fixed priority pick
    always_comb begin
        if (mmu_fault)   ev = EV_MMU;
        else if (hw_ok)  ev = EV_HW;
        else if (brk_ok) ev = EV_BRK;
        else if (irq_ok) ev = EV_IRQ;
        else             ev = EV_NONE;
    end
endmodule

// File: rtl/exc_target.sv
// Computes the vector, return register, return address and the
// syndrome / fault-address / branch-target updates for one event.
// Purely combinational; assumes ev is already arbitrated.
module exc_target
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] BASE_VEC = '0
) (
    input  ev_e               ev,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              in_dslot,
    input  logic              in_imm,
    input  logic              in_bimm,
    input  logic [4:0]        hwexc_cause,
    input  logic              mmu_miss,
    input  logic              mmu_fetch,
    input  logic              mmu_store,
    output logic [XLEN-1:0]   vec,
    output logic [RIDX_W-1:0] ridx,
    output logic [XLEN-1:0]   ret,
    output logic              esr_we,
    output logic [XLEN-1:0]   esr_nx,
    output logic              ear_we,
    output logic              btr_we
);
    logic [4:0]      mmu_code;
    logic [XLEN-1:0] mmu_ret;

    // syndrome code: +2 for miss, +1 for fetch
    always_comb begin
        mmu_code = MMU_CODE_BASE + {3'b000, mmu_miss, mmu_fetch};
    end

    // rewind so that a faulting branch or prefix runs again
    always_comb begin
        if (in_dslot)    mmu_ret = cur_pc - (in_bimm ? XLEN'(8) : XLEN'(4));
        else if (in_imm) mmu_ret = cur_pc - XLEN'(4);
        else             mmu_ret = cur_pc;
    end

    // per-event selection of vector, return value and side effects
    always_comb begin
        vec    = '0;
        ridx   = '0;
        ret    = '0;
        esr_we = 1'b0;
        esr_nx = '0;
        ear_we = 1'b0;
        btr_we = 1'b0;
        unique case (ev)
            EV_MMU: begin
                vec    = BASE_VEC + OFS_EXC;
                ridx   = RA_EXC;
                ret    = mmu_ret;
                esr_we = 1'b1;
                esr_nx[4:0]      = mmu_code;
                esr_nx[ES_STORE] = mmu_store;
                esr_nx[ES_DS]    = in_dslot;
                ear_we = 1'b1;
                btr_we = in_dslot;
            end
            EV_HW: begin
                vec    = BASE_VEC + OFS_EXC;
                ridx   = RA_EXC;
                ret    = cur_pc + XLEN'(4);
                esr_we = 1'b1;
                esr_nx[4:0]   = hwexc_cause;
                esr_nx[ES_DS] = in_dslot;
                btr_we = in_dslot;
            end
            EV_BRK: begin
                vec  = BASE_VEC + OFS_BRK;
                ridx = RA_BRK;
                ret  = cur_pc;
            end
            EV_IRQ: begin
                vec  = BASE_VEC + OFS_IRQ;
                ridx = RA_IRQ;
                ret  = cur_pc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_status.sv
// Builds the status value written on entry. It saves the user and
// translation mode bits one position up, clears the live copies, and
// applies the per-event in-progress or enable change.
module exc_status
    import exc_entry_pkg::*;
(
    input  ev_e             ev,
    input  logic [XLEN-1:0] stat_cur,
    output logic [XLEN-1:0] stat_nx
);
    localparam int MODE_POS [N_MODE] = '{ST_UM, ST_VM};

    logic [XLEN-1:0] saved;

    // mode save: one generate lane per mode bit
    always_comb begin
        saved = stat_cur;
        for (int i = 0; i < N_MODE; i++) begin
            saved[MODE_POS[i] + 1] = stat_cur[MODE_POS[i]];
            saved[MODE_POS[i]]     = 1'b0;
        end
    end

    // apply the event-specific status bit
    always_comb begin
        stat_nx = saved;
        unique case (ev)
            EV_IRQ:         stat_nx[ST_IE]  = 1'b0;
            EV_BRK:         stat_nx[ST_BIP] = 1'b1;
            EV_MMU, EV_HW:  stat_nx[ST_EIP] = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception and interrupt entry controller. Samples events each cycle,
// performs one entry per edge and presents the redirect for one cycle.
// Assumes the pipeline holds its flags stable for the sampled cycle.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] BASE_VEC = '0,
    parameter bit              EXC_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              hwexc_req,
    input  logic [4:0]        hwexc_cause,
    input  logic              mmu_fault,
    input  logic              mmu_miss,
    input  logic              mmu_fetch,
    input  logic              mmu_store,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic              brk_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   br_target,
    input  logic              in_dslot,
    input  logic              in_imm,
    input  logic              in_bimm,
    input  logic              stat_wr_en,
    input  logic [XLEN-1:0]   stat_wr_data,
    input  logic              resv_set,
    output logic              flush,
    output logic [XLEN-1:0]   new_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [XLEN-1:0]   rf_data,
    output logic [XLEN-1:0]   stat_q,
    output logic [XLEN-1:0]   esr_q,
    output logic [XLEN-1:0]   ear_q,
    output logic [XLEN-1:0]   btr_q,
    output logic              resv_valid
);
    ev_e               ev;
    logic              take;
    logic [XLEN-1:0]   vec;
    logic [RIDX_W-1:0] ridx;
    logic [XLEN-1:0]   ret;
    logic              esr_we;
    logic [XLEN-1:0]   esr_nx;
    logic              ear_we;
    logic              btr_we;
    logic [XLEN-1:0]   stat_nx;

    exc_arbiter #(.EXC_EN(EXC_EN)) u_arb (
        .irq_req   (irq_req),
        .hwexc_req (hwexc_req),
        .mmu_fault (mmu_fault),
        .brk_req   (brk_req),
        .st_ie     (stat_q[ST_IE]),
        .st_bip    (stat_q[ST_BIP]),
        .st_eip    (stat_q[ST_EIP]),
        .in_dslot  (in_dslot),
        .in_imm    (in_imm),
        .ev        (ev)
    );

    exc_target #(.BASE_VEC(BASE_VEC)) u_tgt (
        .ev          (ev),
        .cur_pc      (cur_pc),
        .in_dslot    (in_dslot),
        .in_imm      (in_imm),
        .in_bimm     (in_bimm),
        .hwexc_cause (hwexc_cause),
        .mmu_miss    (mmu_miss),
        .mmu_fetch   (mmu_fetch),
        .mmu_store   (mmu_store),
        .vec         (vec),
        .ridx        (ridx),
        .ret         (ret),
        .esr_we      (esr_we),
        .esr_nx      (esr_nx),
        .ear_we      (ear_we),
        .btr_we      (btr_we)
    );

    exc_status u_st (
        .ev       (ev),
        .stat_cur (stat_q),
        .stat_nx  (stat_nx)
    );

    // an entry is made whenever the arbiter picked an event
    always_comb begin
        take = (ev != EV_NONE);
    end

    // one-cycle redirect pulse and register-file write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush   <= 1'b0;
            rf_we   <= 1'b0;
            new_pc  <= '0;
            rf_idx  <= '0;
            rf_data <= '0;
        end else begin
            flush <= take;
            rf_we <= take;
            if (take) begin
                new_pc  <= vec;
                rf_idx  <= ridx;
                rf_data <= ret;
            end
        end
    end

    // status register: entry value wins over the pipeline write
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_q <= '0;
        else if (take)       stat_q <= stat_nx;
        else if (stat_wr_en) stat_q <= stat_wr_data;
    end

    // syndrome, fault address and saved branch target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= '0;
            ear_q <= '0;
            btr_q <= '0;
        end else begin
            if (esr_we) esr_q <= esr_nx;
            if (ear_we) ear_q <= fault_addr;
            if (btr_we) btr_q <= br_target;
        end
    end

    // load-reserved reservation, dropped on any entry
    always_ff @(posedge clk) begin
        if (!rst_n)        resv_valid <= 1'b0;
        else if (take)     resv_valid <= 1'b0;
        else if (resv_set) resv_valid <= 1'b1;
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the entry controller, bound to every instance.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] BASE_VEC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_idx,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   stat_q,
    input logic              resv_valid
);
    // R4
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && rf_idx == RA_IRQ) |-> (!stat_q[ST_IE] && new_pc == BASE_VEC + OFS_IRQ));

    // R5
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && rf_idx == RA_BRK) |-> (stat_q[ST_BIP] && new_pc == BASE_VEC + OFS_BRK));

    // R6
    exc_entry_chk_p: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && rf_idx == RA_EXC) |-> (stat_q[ST_EIP] && new_pc == BASE_VEC + OFS_EXC));

    // R9
    mode_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stat_q[ST_UM] && !stat_q[ST_VM]
                   && stat_q[ST_UM+1] == $past(stat_q[ST_UM])
                   && stat_q[ST_VM+1] == $past(stat_q[ST_VM])));

    // R10
    resv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!resv_valid && rf_we));

    // R1
    ret_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (rf_idx == RA_IRQ || rf_idx == RA_BRK || rf_idx == RA_EXC));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.BASE_VEC(BASE_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .new_pc     (new_pc),
    .stat_q     (stat_q),
    .resv_valid (resv_valid)
);

// File: tb/exc_entry_ctrl_test.sv
// Table-driven bench with a reference model, plus directed corner tests.
module exc_entry_ctrl_test;
    localparam logic [31:0] BASE = 32'h8000_0000;

    typedef struct packed {
        logic [3:0]  ev;      // {mmu, hw, brk, irq}
        logic        miss;
        logic        fetch;
        logic        store;
        logic        ds;
        logic        imm;
        logic        bimm;
        logic [15:0] st;
        logic [31:0] pc;
        logic [31:0] bt;
        logic [31:0] fa;
        logic [4:0]  cause;
    } row_t;

    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2802, 32'h0000_0100, 32'h0, 32'h0, 5'd0},
        '{4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 32'h0000_0204, 32'h0, 32'h0, 5'd0},
        '{4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 32'h0000_0300, 32'h0, 32'h0, 5'd5},
        '{4'b0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 32'h0000_0404, 32'h0000_1230, 32'h0, 5'd3},
        '{4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0802, 32'h0000_0500, 32'h0, 32'hdead_0010, 5'd0},
        '{4'b1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2800, 32'h0000_0610, 32'h0000_2000, 32'h0000_0614, 5'd0},
        '{4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 32'h0000_0708, 32'h0000_3300, 32'hbeef_0004, 5'd0},
        '{4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0002, 32'h0000_0808, 32'h0, 32'h0000_9000, 5'd0},
        '{4'b1111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0002, 32'h0000_0900, 32'h0, 32'h0000_a000, 5'd7},
        '{4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002, 32'h0000_0a00, 32'h0, 32'h0, 5'd9},
        '{4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002, 32'h0000_0b00, 32'h0, 32'h0, 5'd0},
        '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0002, 32'h0000_0c00, 32'h44, 32'h0, 5'd0},
        '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0202, 32'h0000_0d00, 32'h0, 32'h0, 5'd0},
        '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 32'h0000_0e00, 32'h0, 32'h0, 5'd0},
        '{4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000a, 32'h0000_0f00, 32'h0, 32'h0, 5'd0},
        '{4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 32'h0000_1000, 32'h0, 32'h0, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, hwexc_req = 1'b0, mmu_fault = 1'b0, brk_req = 1'b0;
    logic [4:0]  hwexc_cause = '0;
    logic        mmu_miss = 1'b0, mmu_fetch = 1'b0, mmu_store = 1'b0;
    logic [31:0] fault_addr = '0, cur_pc = '0, br_target = '0;
    logic        in_dslot = 1'b0, in_imm = 1'b0, in_bimm = 1'b0;
    logic        stat_wr_en = 1'b0, resv_set = 1'b0;
    logic [31:0] stat_wr_data = '0;

    logic        flush, rf_we, resv_valid;
    logic [31:0] new_pc, rf_data, stat_q, esr_q, ear_q, btr_q;
    logic [4:0]  rf_idx;
    logic        nx_flush, nx_rf_we, nx_resv;
    logic [31:0] nx_new_pc, nx_rf_data, nx_stat, nx_esr, nx_ear, nx_btr;
    logic [4:0]  nx_rf_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.BASE_VEC(BASE), .EXC_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .hwexc_req(hwexc_req),
        .hwexc_cause(hwexc_cause), .mmu_fault(mmu_fault), .mmu_miss(mmu_miss),
        .mmu_fetch(mmu_fetch), .mmu_store(mmu_store), .fault_addr(fault_addr),
        .brk_req(brk_req), .cur_pc(cur_pc), .br_target(br_target),
        .in_dslot(in_dslot), .in_imm(in_imm), .in_bimm(in_bimm),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .resv_set(resv_set),
        .flush(flush), .new_pc(new_pc), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_data(rf_data), .stat_q(stat_q), .esr_q(esr_q), .ear_q(ear_q),
        .btr_q(btr_q), .resv_valid(resv_valid)
    );

    exc_entry_ctrl #(.BASE_VEC(BASE), .EXC_EN(1'b0)) uut_nx (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .hwexc_req(hwexc_req),
        .hwexc_cause(hwexc_cause), .mmu_fault(mmu_fault), .mmu_miss(mmu_miss),
        .mmu_fetch(mmu_fetch), .mmu_store(mmu_store), .fault_addr(fault_addr),
        .brk_req(brk_req), .cur_pc(cur_pc), .br_target(br_target),
        .in_dslot(in_dslot), .in_imm(in_imm), .in_bimm(in_bimm),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .resv_set(resv_set),
        .flush(nx_flush), .new_pc(nx_new_pc), .rf_we(nx_rf_we), .rf_idx(nx_rf_idx),
        .rf_data(nx_rf_data), .stat_q(nx_stat), .esr_q(nx_esr), .ear_q(nx_ear),
        .btr_q(nx_btr), .resv_valid(nx_resv)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_req = 1'b0; hwexc_req = 1'b0; mmu_fault = 1'b0; brk_req = 1'b0;
        in_dslot = 1'b0; in_imm = 1'b0; in_bimm = 1'b0;
        mmu_miss = 1'b0; mmu_fetch = 1'b0; mmu_store = 1'b0;
        stat_wr_en = 1'b0; resv_set = 1'b0;
    endtask

    // write a status value and arm the reservation
    task automatic preset(input logic [31:0] st);
        @(negedge clk);
        idle_inputs();
        stat_wr_en = 1'b1; stat_wr_data = st; resv_set = 1'b1;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] m_esr, m_ear, m_btr;
        m_esr = '0; m_ear = '0; m_btr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "flush", {31'b0, flush}, 32'h0);
        chk("R12", "rf_we", {31'b0, rf_we}, 32'h0);
        chk("R12", "new_pc", new_pc, 32'h0);
        chk("R12", "stat", stat_q, 32'h0);
        chk("R12", "esr", esr_q, 32'h0);
        chk("R12", "ear", ear_q, 32'h0);
        chk("R12", "btr", btr_q, 32'h0);
        chk("R12", "resv", {31'b0, resv_valid}, 32'h0);

        for (int r = 0; r < NROW; r++) begin
            row_t t;
            int   kind;    // 0 none, 1 mmu, 2 hw, 3 brk, 4 irq
            logic [31:0] s, es, evec, eret;
            logic [4:0]  eidx;
            string rtag;
            t = TBL[r];
            preset({16'h0, t.st});
            mmu_fault = t.ev[3]; hwexc_req = t.ev[2]; brk_req = t.ev[1]; irq_req = t.ev[0];
            mmu_miss = t.miss; mmu_fetch = t.fetch; mmu_store = t.store;
            in_dslot = t.ds; in_imm = t.imm; in_bimm = t.bimm;
            cur_pc = t.pc; br_target = t.bt; fault_addr = t.fa; hwexc_cause = t.cause;

            // reference model from the requirements
            s = {16'h0, t.st};
            if (t.ev[3]) kind = 1;
            else if (t.ev[2]) kind = 2;
            else if (t.ev[1] && !s[3] && !t.ds && !t.imm) kind = 3;
            else if (t.ev[0] && s[1] && !s[9] && !s[3] && !t.ds && !t.imm) kind = 4;
            else kind = 0;
            evec = '0; eret = '0; eidx = '0; rtag = "R3";
            if (kind != 0) begin
                s = (s & ~32'h0000_7800) | ((s & 32'h0000_2800) << 1);
            end
            case (kind)
                1: begin
                    evec = BASE + 32'h20; eidx = 5'd17; rtag = "R7";
                    s[9] = 1'b1;
                    if (t.ds) eret = t.pc - (t.bimm ? 32'd8 : 32'd4);
                    else if (t.imm) eret = t.pc - 32'd4;
                    else eret = t.pc;
                    es = 32'd16 + (t.miss ? 32'd2 : 32'd0) + (t.fetch ? 32'd1 : 32'd0);
                    es[10] = t.store; es[12] = t.ds;
                    m_esr = es; m_ear = t.fa;
                    if (t.ds) m_btr = t.bt;
                end
                2: begin
                    evec = BASE + 32'h20; eidx = 5'd17; rtag = "R6";
                    s[9] = 1'b1; eret = t.pc + 32'd4;
                    es = {27'b0, t.cause}; es[12] = t.ds;
                    m_esr = es;
                    if (t.ds) m_btr = t.bt;
                end
                3: begin
                    evec = BASE + 32'h18; eidx = 5'd16; rtag = "R5";
                    s[3] = 1'b1; eret = t.pc;
                end
                4: begin
                    evec = BASE + 32'h10; eidx = 5'd14; rtag = "R4";
                    s[1] = 1'b0; eret = t.pc;
                end
                default: ;
            endcase
            if (t.ev[1] && kind == 0) rtag = "R5";

            @(negedge clk);
            idle_inputs();
            chk(rtag, "flush", {31'b0, flush}, {31'b0, kind != 0});
            chk("R9", "stat", stat_q, s);
            chk(kind == 1 ? "R8" : "R6", "esr", esr_q, m_esr);
            chk("R8", "ear", ear_q, m_ear);
            chk("R8", "btr", btr_q, m_btr);
            chk("R10", "resv", {31'b0, resv_valid}, {31'b0, kind == 0});
            if (kind != 0) begin
                chk("R1", "vector", new_pc, evec);
                chk("R2", "ret idx", {27'b0, rf_idx}, {27'b0, eidx});
                chk(rtag, "ret value", rf_data, eret);
                chk("R10", "rf_we", {31'b0, rf_we}, 32'h1);
                @(negedge clk);
                chk("R10", "flush width", {31'b0, flush}, 32'h0);
            end
        end

        // R11: exception ignored without support, interrupt still taken
        begin
            logic [31:0] esr0, stat0;
            preset(32'h0000_0002);
            hwexc_req = 1'b1; irq_req = 1'b1; hwexc_cause = 5'd4; cur_pc = 32'h0000_2220;
            @(negedge clk);
            idle_inputs();
            chk("R11", "nx ret idx", {27'b0, nx_rf_idx}, 32'd14);
            chk("R11", "nx vector", nx_new_pc, BASE + 32'h10);
            chk("R2", "uut ret idx", {27'b0, rf_idx}, 32'd17);
            preset(32'h0000_0800);
            esr0 = nx_esr; stat0 = nx_stat;
            hwexc_req = 1'b1; hwexc_cause = 5'd6;
            @(negedge clk);
            idle_inputs();
            chk("R11", "nx flush", {31'b0, nx_flush}, 32'h0);
            chk("R11", "nx esr", nx_esr, esr0);
            chk("R11", "nx stat", nx_stat, stat0);
            chk("R11", "nx resv", {31'b0, nx_resv}, 32'h1);
        end

        // R13: status write lost when an entry happens the same cycle
        preset(32'h0000_0002);
        irq_req = 1'b1; cur_pc = 32'h0000_3330;
        stat_wr_en = 1'b1; stat_wr_data = 32'h0000_ffff;
        @(negedge clk);
        idle_inputs();
        chk("R13", "stat on entry", stat_q, 32'h0);
        chk("R4", "irq ret", rf_data, 32'h0000_3330);
        // R13: plain write lands when idle
        stat_wr_en = 1'b1; stat_wr_data = 32'h1234_5670;
        @(negedge clk);
        idle_inputs();
        chk("R13", "stat write", stat_q, 32'h1234_5670);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule